// File: doc/BRIEF.md
# Write-Buffer Parity Error Logger

This block gathers parity error strobes from the four internal data paths of a posted write buffer and keeps them in two 8-bit status registers. The capture register holds the error (or errors) that arrived first. Once it holds anything it is locked, and later errors collect in an accumulation register. Software reads either register through a small register port and clears bits by writing ones. A summary output stays high while any status bit is set, so it can feed a non-fatal error report.

A two-state machine controls the capture register. In `FIRST_OPEN` the register is empty. Any nonzero strobe vector moves it to `FIRST_HELD`, and every strobe raised in that cycle is latched together. In `FIRST_HELD` new strobes go to the accumulation register. When every held bit has been cleared, the machine returns to `FIRST_OPEN`. The clear has to take effect in the register before it counts as empty. Only the cold power-on reset forces `FIRST_OPEN` and zeroes both registers. The warm reset input does not touch the status bits.

Top module: `buf_err_log`

## Requirements
- R1: While the cold reset `por_n` is low, both status registers read 00h and `nonfatal_o` is 0.
- R2: Strobe `err_i[k]` maps to status bit k in both registers. The bits mean: bit 0 is a parity error on a buffer flush to DRAM, bit 1 is on the buffer-to-system-bus path, bit 2 is on a line write from the system bus or I/O into the buffer, and bit 3 is on a DRAM line read into the buffer during a partial-write read-modify-write.
- R3: When the capture register (offset 70h) is empty, a nonzero strobe vector is latched into it at the next clock edge.
- R4: All strobes raised in the capturing cycle are latched into the capture register together.
- R5: While the capture register is nonzero, no bit of it can become set.
- R6: Strobes raised while the capture register is nonzero are ORed into the accumulation register (offset 72h).
- R7: Strobes that are latched into the capture register are not also recorded in the accumulation register.
- R8: Writing 1 to a bit of either register clears it. Writing 0 leaves it unchanged. Only the addressed register is affected.
- R9: If a strobe and a write-1-to-clear hit the same accumulation bit in the same cycle, the bit ends up set.
- R10: A clear that empties the capture register takes effect before the register counts as empty. A strobe in the clearing cycle goes to the accumulation register, and the capture register reads 00h afterwards.
- R11: Holding the warm reset `warm_rst_n` low leaves both registers unchanged.
- R12: Bits 7:4 of both registers always read 0, and writes to them are ignored. Any other address reads 00h.
- R13: `nonfatal_o` is 1 exactly when some bit of either register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset, active low; status bits are kept |
| err_i | input | 4 | Single-cycle parity error strobes, one per data path |
| reg_addr | input | 8 | Register address (70h capture, 72h accumulation) |
| reg_wdata | input | 8 | Write data; ones select bits to clear |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| nonfatal_o | output | 1 | Set while any status bit is set |

## Verification
The tests apply single strobes, multi-bit strobe vectors in the capturing cycle, and strobes that arrive while the capture register is locked. Together these separate a register that latches all first-cycle errors from one that keeps only one of them, and a locked register from one that keeps absorbing errors. Clears are tried with all-zero, partial, reserved-bit and full masks. A strobe is also raised in the same cycle as a clear on the same bit, and in the same cycle as the clear that empties the capture register. These cases show set-over-clear priority and show that emptiness is decided from the registered value. Warm-reset pulses and a cold reset with bits set show which reset clears the status.

// File: rtl/buf_err_pkg.sv
package buf_err_pkg;

    typedef enum logic [0:0] {
        FIRST_OPEN = 1'b0,
        FIRST_HELD = 1'b1
    } first_state_e;

endpackage

// File: rtl/err_first_reg.sv
module err_first_reg
    import buf_err_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] first_q,
    output logic               capture_o,
    output logic               route_next_o
);

    first_state_e state_q, state_d;
    logic [NUM_SRC-1:0] first_d;
    logic               any_err;

    assign any_err = |err_i;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= FIRST_OPEN;
            first_q <= '0;
        end else begin
            state_q <= state_d;
            first_q <= first_d;
        end
    end

    // next state and register data
    always_comb begin
        state_d = state_q;
        first_d = first_q;
        unique case (state_q)
            FIRST_OPEN: begin
                if (any_err) begin
                    state_d = FIRST_HELD;
                    first_d = err_i;
                end
            end
            FIRST_HELD: begin
                first_d = first_q & ~clr_i;
                if ((first_q & ~clr_i) == '0) begin
                    state_d = FIRST_OPEN;
                end
            end
            default: state_d = FIRST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        capture_o    = 1'b0;
        route_next_o = 1'b0;
        unique case (state_q)
            FIRST_OPEN: capture_o    = any_err;
            FIRST_HELD: route_next_o = 1'b1;
            default:    route_next_o = 1'b0;
        endcase
    end

    assert_capture_all_R4: assert property (@(posedge clk) disable iff (!por_n)
        ((first_q == '0) && (err_i != '0)) |=> (first_q == $past(err_i)));

    assert_locked_R5: assert property (@(posedge clk) disable iff (!por_n)
        (first_q != '0) |=> ((first_q | $past(first_q)) == $past(first_q)));

    assert_state_tracks_R10: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == FIRST_HELD) == (first_q != '0));

endmodule

// File: rtl/err_next_reg.sv
module err_next_reg #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic               accept_i,
    input  logic               capture_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] next_q
);

    logic [NUM_SRC-1:0] set_v;

    assign set_v = accept_i ? err_i : '0;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            next_q <= '0;
        end else begin
            next_q <= (next_q & ~clr_i) | set_v;
        end
    end

    assert_accumulate_R6: assert property (@(posedge clk) disable iff (!por_n)
        (accept_i && (err_i != '0)) |=> ((next_q & $past(err_i)) == $past(err_i)));

    assert_no_dup_R7: assert property (@(posedge clk) disable iff (!por_n)
        capture_i |=> ((next_q & ~$past(next_q)) == '0));

endmodule

// File: rtl/err_reg_port.sv
module err_reg_port #(
    parameter int          NUM_SRC    = 4,
    parameter int          REG_W      = 8,
    parameter int          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] FIRST_ADDR = 8'h70,
    parameter logic [ADDR_W-1:0] NEXT_ADDR  = 8'h72
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic               we_i,
    input  logic [NUM_SRC-1:0] first_i,
    input  logic [NUM_SRC-1:0] next_i,
    output logic [NUM_SRC-1:0] clr_first_o,
    output logic [NUM_SRC-1:0] clr_next_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam int RSVD_W = REG_W - NUM_SRC;

    logic hit_first, hit_next;
    logic unused_rsvd_wdata;

    assign hit_first = (addr_i == FIRST_ADDR);
    assign hit_next  = (addr_i == NEXT_ADDR);

    // reserved write bits are dropped here
    assign unused_rsvd_wdata = ^wdata_i[REG_W-1:NUM_SRC];

    assign clr_first_o = wdata_i[NUM_SRC-1:0] & {NUM_SRC{we_i & hit_first}};
    assign clr_next_o  = wdata_i[NUM_SRC-1:0] & {NUM_SRC{we_i & hit_next}};

    always_comb begin
        rdata_o = '0;
        if (hit_first) begin
            rdata_o = {{RSVD_W{1'b0}}, first_i};
        end else if (hit_next) begin
            rdata_o = {{RSVD_W{1'b0}}, next_i};
        end
    end

endmodule

// File: rtl/buf_err_log.sv
module buf_err_log
    import buf_err_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int REG_W   = 8,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic [NUM_SRC-1:0] err_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nonfatal_o
);

    logic [NUM_SRC-1:0] first_q, next_q;
    logic [NUM_SRC-1:0] clr_first, clr_next;
    logic               capture, route_next;
    logic               unused_warm;

    // the warm reset deliberately does not reach the status bits
    assign unused_warm = warm_rst_n;

    err_first_reg #(.NUM_SRC(NUM_SRC)) u_first (
        .clk          (clk),
        .por_n        (por_n),
        .err_i        (err_i),
        .clr_i        (clr_first),
        .first_q      (first_q),
        .capture_o    (capture),
        .route_next_o (route_next)
    );

    err_next_reg #(.NUM_SRC(NUM_SRC)) u_next (
        .clk       (clk),
        .por_n     (por_n),
        .err_i     (err_i),
        .accept_i  (route_next),
        .capture_i (capture),
        .clr_i     (clr_next),
        .next_q    (next_q)
    );

    err_reg_port #(
        .NUM_SRC (NUM_SRC),
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W)
    ) u_port (
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .we_i        (reg_we),
        .first_i     (first_q),
        .next_i      (next_q),
        .clr_first_o (clr_first),
        .clr_next_o  (clr_next),
        .rdata_o     (reg_rdata)
    );

    assign nonfatal_o = |{first_q, next_q};

    assert_warm_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_rst_n && (err_i == '0) && !reg_we) |=> ($stable(first_q) && $stable(next_q)));

    assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[REG_W-1:NUM_SRC] == '0);

    assert_wclr_R8: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && (err_i == '0) && (clr_next != '0)) |=> ((next_q & $past(clr_next)) == '0));

endmodule

// File: tb/buf_err_log_test.sv
module buf_err_log_test;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        logic       nf;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic [3:0] err_i = '0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       nonfatal_o;

    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    item_t sb[$];

    logic [3:0] mf = '0;
    logic [3:0] mn = '0;

    always #5 clk = ~clk;

    buf_err_log uut (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .err_i      (err_i),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata),
        .nonfatal_o (nonfatal_o)
    );

    // monitor: compares one expected item per read cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_vec++;
            if (reg_rdata !== it.d || nonfatal_o !== it.nf) begin
                n_fail++;
                $display("FAIL %s addr=%02h rdata=%02h nf=%0b expected rdata=%02h nf=%0b",
                         it.tag, it.a, reg_rdata, nonfatal_o, it.d, it.nf);
            end
        end
    end

    // one cycle of stimulus; the model tracks the state after the next edge
    task automatic cyc(input logic [3:0] e, input logic we, input logic [7:0] a,
                       input logic [7:0] wd);
        logic [3:0] cf, cn;
        @(posedge clk); #2;
        err_i = e; reg_we = we; reg_addr = a; reg_wdata = wd;
        cf = (we && a == 8'h70) ? wd[3:0] : 4'h0;
        cn = (we && a == 8'h72) ? wd[3:0] : 4'h0;
        if (mf == 4'h0 && e != 4'h0) begin
            mf = e;
            mn = mn & ~cn;
        end else begin
            mf = mf & ~cf;
            mn = (mn & ~cn) | e;
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        item_t it;
        @(posedge clk); #2;
        err_i = '0; reg_we = 1'b0; reg_addr = a; reg_wdata = '0;
        it.a  = a;
        it.d  = (a == 8'h70) ? {4'h0, mf} : (a == 8'h72) ? {4'h0, mn} : 8'h00;
        it.nf = (mf != 4'h0) || (mn != 4'h0);
        it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 por_n = 1'b1;

        // reset state
        rd(8'h70, "R1 capture after cold reset");
        rd(8'h72, "R1 accumulation after cold reset");
        rd(8'h74, "R12 unmapped address");

        // first capture of a single error
        cyc(4'h1, 1'b0, 8'h00, 8'h00);
        rd(8'h70, "R2 R3 flush path captured in bit 0");
        rd(8'h72, "R7 captured error not in accumulation");

        // locked: later errors accumulate
        cyc(4'h4, 1'b0, 8'h00, 8'h00);
        rd(8'h70, "R5 capture locked");
        rd(8'h72, "R6 bus write error accumulated");
        cyc(4'h2, 1'b0, 8'h00, 8'h00);
        rd(8'h72, "R6 R2 OR of bus and buffer-to-bus errors");

        // write-1-to-clear, zero bits leave state alone
        cyc(4'h0, 1'b1, 8'h72, 8'h02);
        rd(8'h72, "R8 clear only written bit");
        cyc(4'h0, 1'b1, 8'h70, 8'h00);
        rd(8'h70, "R8 zero write no effect");
        cyc(4'h0, 1'b1, 8'h70, 8'hF1);
        rd(8'h70, "R8 R12 capture cleared, reserved ignored");
        rd(8'h72, "R8 other register untouched");

        // multiple errors in the capturing cycle
        cyc(4'hA, 1'b0, 8'h00, 8'h00);
        rd(8'h70, "R4 all first-cycle errors latched");
        rd(8'h72, "R7 accumulation unchanged on capture");

        // set wins over clear
        cyc(4'h4, 1'b1, 8'h72, 8'h04);
        rd(8'h72, "R9 set wins on same bit");
        cyc(4'h0, 1'b1, 8'h72, 8'hFF);
        rd(8'h72, "R8 full clear of accumulation");
        cyc(4'h8, 1'b1, 8'h72, 8'h08);
        rd(8'h72, "R9 set wins after clear to zero");

        // clear empties capture in same cycle as a new error
        cyc(4'h1, 1'b1, 8'h70, 8'h0A);
        rd(8'h70, "R10 capture empty after clear");
        rd(8'h72, "R10 error during clear goes to accumulation");
        cyc(4'h2, 1'b0, 8'h00, 8'h00);
        rd(8'h70, "R3 new capture after register emptied");

        // warm reset has no effect
        @(posedge clk); #2;
        err_i = '0; reg_we = 1'b0;
        warm_rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 warm_rst_n = 1'b1;
        rd(8'h70, "R11 capture kept over warm reset");
        rd(8'h72, "R11 accumulation kept over warm reset");

        // summary output tracks contents
        cyc(4'h0, 1'b1, 8'h70, 8'hFF);
        rd(8'h70, "R13 one register still nonzero");
        cyc(4'h0, 1'b1, 8'h72, 8'hFF);
        rd(8'h72, "R13 summary low when all clear");

        // cold reset clears
        cyc(4'h5, 1'b0, 8'h00, 8'h00);
        cyc(4'h2, 1'b0, 8'h00, 8'h00);
        rd(8'h72, "R6 state before cold reset");
        @(posedge clk); #2;
        err_i = '0;
        por_n = 1'b0;
        mf = '0; mn = '0;
        rd(8'h70, "R1 capture in cold reset");
        rd(8'h72, "R1 accumulation in cold reset");
        @(posedge clk); #2 por_n = 1'b1;
        rd(8'h70, "R1 capture after cold reset release");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule